// File: doc/BRIEF.md
# Aliased Interrupt Control Register

This block holds one 64-bit control word on a small synchronous register bus and turns its most significant bit into a level interrupt. Software reaches the word through three neighbouring word offsets. The first overwrites the word. The second modifies it in place. The third sets bits in it. Only the top 16 bits of the word are ever kept. The lower 48 bits always read as zero, so any update behaves the same whatever arrives in the low data bits.

An elaboration parameter picks one of two generations. The generations differ in two ways. The first is the base word offset. The second is what the modify alias does: in generation 0 it ANDs the write data into the word, and in generation 1 it clears the word and ignores the data.

The bus is single-cycle with no handshake:
- A request is sampled on the clock edge where it is valid.
- Read data and the unimplemented-access flag appear one cycle after the request.
- The interrupt output follows the stored top bit one cycle after the word changes.

Top module: `irq_alias_reg`

## Requirements
- R1: The word offset is the byte address shifted right by 3, so the three low address bits are ignored. The base offset is 0x4020 when GEN=0 and 0x6080 when GEN=1. The load alias is at base, the modify alias at base+1 and the set alias at base+2.
- R2: A write of 8 bytes to the base offset stores the write data with bits 47..0 forced to zero.
- R3: With GEN=0, a write to base+1 stores (word AND write data), with bits 47..0 zero.
- R4: With GEN=1, a write to base+1 clears the whole word to zero, whatever the write data.
- R5: A write to base+2 stores (word OR write data), with bits 47..0 zero.
- R6: An 8-byte read of the base offset returns the stored word on rsp_rdata in the following cycle. Any other read returns zero, and rsp_rdata is zero in every cycle that does not follow such a read.
- R7: unimpl_o pulses high for exactly one cycle, one cycle after any of these requests:
  - a read of any offset other than base;
  - a write to any offset outside base..base+2;
  - any request whose byte count is not 8.
- R8: A write flagged by R7 leaves the stored word unchanged.
- R9: irq_o equals bit 63 of the stored word, delayed by one cycle. After a write that changes bit 63, irq_o changes one cycle after the write is accepted.
- R10: While rst_n is low, the word, irq_o, unimpl_o and rsp_rdata are all zero. The reset asserts asynchronously and is released on a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (24) | Byte address; word offset is bits ADDR_W-1..3 |
| req_bytes | input | 4 | Access size in bytes; only 8 is accepted |
| req_wdata | input | DATA_W (64) | Write data, bit 63 most significant |
| rsp_rdata | output | DATA_W (64) | Read data, valid one cycle after a read |
| irq_o | output | 1 | Level interrupt from the stored top bit |
| unimpl_o | output | 1 | One-cycle pulse for an undecoded or wrongly sized access |

## Verification
Every cycle, the assertions check several relations between requests and what follows:
- a flagged request is followed by the unimplemented pulse;
- a flagged write leaves the stored word unchanged;
- reads outside the base offset return zero;
- the set alias never clears a bit;
- in generation 1, the modify alias empties the word.

The assertions also check that a load with bit 63 set raises the interrupt two cycles later.

Some behaviour depends on the running value of the word across a chain of writes, and only the bench scenarios show it. This covers the exact AND and OR results of the aliases, the masking of the low bits, and the difference between the generations for the same stimulus. The same holds for the exact cycle in which irq_o moves, for a mid-run reset, and for address low bits being ignored.

// File: rtl/irq_alias_pkg.sv
package irq_alias_pkg;

  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_READ   = 3'd1,
    OP_LOAD   = 3'd2,
    OP_MODIFY = 3'd3,
    OP_SET    = 3'd4,
    OP_BAD    = 3'd5
  } iar_op_e;

  localparam int unsigned ACCESS_BYTES = 8;

  // Base word offset of the three aliases for each generation.
  function automatic int unsigned base_offset(input int unsigned gen);
    return (gen == 0) ? 32'h4020 : 32'h6080;
  endfunction

endpackage

// File: rtl/iar_rst_sync.sv
module iar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/iar_decode.sv
module iar_decode
  import irq_alias_pkg::*;
#(
  parameter int unsigned GEN    = 0,
  parameter int unsigned ADDR_W = 24
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  output iar_op_e           op
);
  localparam int unsigned OFF_W = ADDR_W - 3;
  localparam logic [OFF_W-1:0] BASE = OFF_W'(base_offset(GEN));
  localparam logic [OFF_W-1:0] ALIAS_MOD = BASE + OFF_W'(1);
  localparam logic [OFF_W-1:0] ALIAS_SET = BASE + OFF_W'(2);

  logic [OFF_W-1:0] offset;
  logic             size_ok;

  assign offset  = req_addr[ADDR_W-1:3];
  assign size_ok = (req_bytes == 4'(ACCESS_BYTES));

  always_comb begin
    op = OP_IDLE;
    if (req_valid) begin
      if (!size_ok) begin
        op = OP_BAD;
      end else if (!req_write) begin
        op = (offset == BASE) ? OP_READ : OP_BAD;
      end else if (offset == BASE) begin
        op = OP_LOAD;
      end else if (offset == ALIAS_MOD) begin
        op = OP_MODIFY;
      end else if (offset == ALIAS_SET) begin
        op = OP_SET;
      end else begin
        op = OP_BAD;
      end
    end
  end
endmodule

// File: rtl/iar_store.sv
module iar_store
  import irq_alias_pkg::*;
#(
  parameter int unsigned GEN    = 0,
  parameter int unsigned KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  iar_op_e           op,
  input  logic [KEEP_W-1:0] wdata_hi,
  output logic [KEEP_W-1:0] word_q
);
  logic [KEEP_W-1:0] word_d;
  logic [KEEP_W-1:0] modify_val;
  logic              word_en;

  generate
    if (GEN == 0) begin : g_and_alias
      assign modify_val = word_q & wdata_hi;
    end else begin : g_clear_alias
      assign modify_val = '0;
    end
  endgenerate

  always_comb begin
    word_d  = word_q;
    word_en = 1'b0;
    case (op)
      OP_LOAD:   begin word_d = wdata_hi;          word_en = 1'b1; end
      OP_MODIFY: begin word_d = modify_val;        word_en = 1'b1; end
      OP_SET:    begin word_d = word_q | wdata_hi; word_en = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  // R5: the set alias never clears a bit that was already set.
  a_r5_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> ((word_q & $past(word_q)) == $past(word_q)));

  generate
    if (GEN != 0) begin : g_clear_check
      // R4: the generation-1 modify alias empties the word.
      a_r4_modify_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MODIFY) |=> (word_q == '0));
    end
  endgenerate
endmodule

// File: rtl/iar_resp.sv
module iar_resp
  import irq_alias_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  iar_op_e           op,
  input  logic [KEEP_W-1:0] word_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              irq_q,
  output logic              unimpl_q
);
  localparam int unsigned LOW_W = DATA_W - KEEP_W;

  logic [DATA_W-1:0] rdata_d;
  logic              unimpl_d;
  logic              irq_d;

  always_comb begin
    rdata_d  = (op == OP_READ) ? {word_q, {LOW_W{1'b0}}} : '0;
    unimpl_d = (op == OP_BAD);
    irq_d    = word_q[KEEP_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      irq_q    <= 1'b0;
      unimpl_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      irq_q    <= irq_d;
      unimpl_q <= unimpl_d;
    end
  end
endmodule

// File: rtl/irq_alias_reg.sv
module irq_alias_reg
  import irq_alias_pkg::*;
#(
  parameter int unsigned GEN    = 0,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_bytes,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq_o,
  output logic              unimpl_o
);
  localparam int unsigned OFF_W = ADDR_W - 3;
  localparam logic [OFF_W-1:0] BASE = OFF_W'(base_offset(GEN));

  logic              rst_n_sync;
  iar_op_e           op;
  logic [KEEP_W-1:0] word_q;

  iar_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  iar_decode #(.GEN(GEN), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_bytes (req_bytes),
    .op        (op)
  );

  iar_store #(.GEN(GEN), .KEEP_W(KEEP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .op       (op),
    .wdata_hi (req_wdata[DATA_W-1 -: KEEP_W]),
    .word_q   (word_q)
  );

  iar_resp #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .op       (op),
    .word_q   (word_q),
    .rdata_q  (rsp_rdata),
    .irq_q    (irq_o),
    .unimpl_q (unimpl_o)
  );

  // R7: a request of the wrong size is flagged in the next cycle.
  a_r7_size_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_bytes != 4'(ACCESS_BYTES)) |=> unimpl_o);

  // R8: a flagged write does not touch the stored word.
  a_r8_bad_write_stable: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_write && op == OP_BAD) |=> $stable(word_q));

  // R6: a read outside the base offset returns zero.
  a_r6_offbase_read_zero: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && !req_write && req_addr[ADDR_W-1:3] != BASE) |=> (rsp_rdata == '0));

  // R9: loading a word with the top bit set raises the interrupt two cycles on.
  a_r9_load_raises_irq: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_write && req_bytes == 4'(ACCESS_BYTES)
     && req_addr[ADDR_W-1:3] == BASE && req_wdata[DATA_W-1]) |=> ##1 irq_o);
endmodule

// File: tb/irq_alias_reg_tb.sv
`timescale 1ns/1ps
module irq_alias_reg_tb;
  localparam int unsigned AW = 24;
  localparam logic [AW-4:0] BASE_A = 21'h4020;
  localparam logic [AW-4:0] BASE_B = 21'h6080;

  typedef struct packed {
    logic [1:0]  op;     // 0 load, 1 modify, 2 set, 3 undecoded offset
    logic [63:0] data;
    logic [15:0] exp_a;  // expected top 16 bits, generation 0
    logic [15:0] exp_b;  // expected top 16 bits, generation 1
    logic        bad;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 64'hDEAD_BEEF_0123_4567, 16'hDEAD, 16'hDEAD, 1'b0},
    '{2'd1, 64'hF0F0_FFFF_FFFF_FFFF, 16'hD0A0, 16'h0000, 1'b0},
    '{2'd2, 64'h0005_FFFF_FFFF_FFFF, 16'hD0A5, 16'h0005, 1'b0},
    '{2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 16'hD0A5, 16'h0005, 1'b1},
    '{2'd2, 64'h8000_0000_0000_0001, 16'hD0A5, 16'h8005, 1'b0},
    '{2'd1, 64'h7FFF_FFFF_FFFF_FFFF, 16'h50A5, 16'h0000, 1'b0},
    '{2'd0, 64'h0000_FFFF_FFFF_FFFF, 16'h0000, 16'h0000, 1'b0},
    '{2'd2, 64'h1234_0000_0000_0000, 16'h1234, 16'h1234, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic valid, write;
  logic [AW-1:0] addr_a, addr_b;
  logic [3:0] nbytes;
  logic [63:0] wdata;
  logic [63:0] rdata_a, rdata_b;
  logic irq_a, irq_b, unimpl_a, unimpl_b;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_alias_reg #(.GEN(0), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_write(write),
    .req_addr(addr_a), .req_bytes(nbytes), .req_wdata(wdata),
    .rsp_rdata(rdata_a), .irq_o(irq_a), .unimpl_o(unimpl_a));

  irq_alias_reg #(.GEN(1), .ADDR_W(AW)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .req_valid(valid), .req_write(write),
    .req_addr(addr_b), .req_bytes(nbytes), .req_wdata(wdata),
    .rsp_rdata(rdata_b), .irq_o(irq_b), .unimpl_o(unimpl_b));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One request cycle; returns at the falling edge after the accepting edge.
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [AW-1:0] b,
                        input logic [63:0] d, input logic [3:0] n);
    @(negedge clk);
    valid = 1'b1; write = wr; addr_a = a; addr_b = b; wdata = d; nbytes = n;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; wdata = '0;
  endtask

  function automatic logic [AW-1:0] byte_addr(input logic [AW-4:0] off);
    return {off, 3'b000};
  endfunction

  task automatic read_base();
    access(1'b0, byte_addr(BASE_A), byte_addr(BASE_B), 64'd0, 4'd8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; write = 1'b0; addr_a = '0; addr_b = '0;
    nbytes = 4'd8; wdata = '0;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero during reset
    check("R10 rdata", rdata_a, 64'd0);
    check("R10 irq", {63'd0, irq_a}, 64'd0);
    check("R10 unimpl", {63'd0, unimpl_a}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R8 R9
    foreach (VEC[i]) begin
      logic [AW-4:0] oa, ob;
      oa = (VEC[i].op == 2'd3) ? 21'h0100 : BASE_A + 21'(VEC[i].op);
      ob = (VEC[i].op == 2'd3) ? 21'h0100 : BASE_B + 21'(VEC[i].op);
      access(1'b1, byte_addr(oa), byte_addr(ob), VEC[i].data, 4'd8);
      check("R7/R8 unimpl gen0", {63'd0, unimpl_a}, {63'd0, VEC[i].bad});
      check("R7/R8 unimpl gen1", {63'd0, unimpl_b}, {63'd0, VEC[i].bad});
      read_base();
      check("R2/R3/R5 word gen0", rdata_a, {VEC[i].exp_a, 48'd0});
      check("R2/R4/R5 word gen1", rdata_b, {VEC[i].exp_b, 48'd0});
      check("R9 irq gen0", {63'd0, irq_a}, {63'd0, VEC[i].exp_a[15]});
      check("R9 irq gen1", {63'd0, irq_b}, {63'd0, VEC[i].exp_b[15]});
    end

    // R6 / R7: read of the modify alias returns zero and is flagged
    access(1'b0, byte_addr(BASE_A + 21'd1), byte_addr(BASE_B + 21'd2), 64'd0, 4'd8);
    check("R6 alias read zero", rdata_a, 64'd0);
    check("R7 alias read flag", {63'd0, unimpl_a}, 64'd1);
    check("R7 alias read flag gen1", {63'd0, unimpl_b}, 64'd1);
    @(negedge clk);
    check("R7 single pulse", {63'd0, unimpl_a}, 64'd0);
    check("R6 idle rdata zero", rdata_a, 64'd0);

    // R1: low address bits ignored on read
    access(1'b0, byte_addr(BASE_A) | 24'd5, byte_addr(BASE_B) | 24'd3, 64'd0, 4'd8);
    check("R1 low bits ignored", rdata_a, {16'h1234, 48'd0});
    // R1: generation-0 base is not decoded by generation 1
    access(1'b1, byte_addr(BASE_A), byte_addr(BASE_A), 64'hFFFF_0000_0000_0000, 4'd8);
    check("R1 gen1 ignores other base", {63'd0, unimpl_b}, 64'd1);
    check("R1 gen0 base decoded", {63'd0, unimpl_a}, 64'd0);
    read_base();
    check("R8 gen1 unchanged", rdata_b, {16'h1234, 48'd0});

    // R7 / R8: wrong size write at base
    access(1'b1, byte_addr(BASE_A), byte_addr(BASE_B), 64'h0000_0000_0000_0000, 4'd4);
    check("R7 size flag", {63'd0, unimpl_a}, 64'd1);
    read_base();
    check("R8 size write ignored", rdata_a, {16'hFFFF, 48'd0});

    // R9: exact interrupt timing after a load clearing bit 63
    access(1'b1, byte_addr(BASE_A), byte_addr(BASE_B), 64'h0001_0000_0000_0000, 4'd8);
    check("R9 irq one cycle late", {63'd0, irq_a}, 64'd1);
    @(negedge clk);
    check("R9 irq falls", {63'd0, irq_a}, 64'd0);
    access(1'b1, byte_addr(BASE_A + 21'd2), byte_addr(BASE_B + 21'd2), 64'h8000_0000_0000_0000, 4'd8);
    check("R9 irq not yet", {63'd0, irq_a}, 64'd0);
    @(negedge clk);
    check("R9 irq rises", {63'd0, irq_a}, 64'd1);

    // R10: reset mid-run clears word and interrupt
    rst_n = 1'b0;
    #1;
    check("R10 irq async clear", {63'd0, irq_a}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_base();
    check("R10 word cleared", rdata_a, 64'd0);
    check("R10 word cleared gen1", rdata_b, 64'd0);

    finish_run();
  end
endmodule